// File: doc/BRIEF.md
# Timed Carrier Detector with Hysteresis

This block decides whether a valid carrier is on the line. Its input is a stream of unsigned received-level samples, each marked by a one-cycle valid strobe. The samples come from a level estimator outside the block. The decision is held back by a persistence window. Carrier is declared only after a programmable number of consecutive strobed samples have been above the acquire threshold. It is withdrawn only after the same number of consecutive samples have been below a loss threshold.

The loss threshold is about 3 dB below the acquire threshold, computed as floor(T·181/256). This gap gives hysteresis, so a level hovering near one threshold cannot make the output chatter. The output is active low. A companion enable models the high-impedance state that the detector output takes during power-down.

Top module: `cdq_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it, `cd_n` is 1 and `cd_oe` is 0. Reset also clears the persistence count, so a full window of qualifying samples is needed after reset.
- R2: With no carrier, a strobe qualifies when `lvl > thr_acq` (strict). `cd_n` goes to 0 on the clock edge that registers the `hold_cnt`-th consecutive qualifying strobe.
- R3: A strobed sample that does not qualify, arriving before the window completes, clears the persistence count.
- R4: With carrier present, the threshold becomes floor(`thr_acq`·181/256) and a strobe qualifies when `lvl` is strictly below it. `cd_n` returns to 1 on the edge of the `hold_cnt`-th consecutive qualifying strobe. A sample between the two thresholds keeps the carrier and clears the count.
- R5: After carrier loss, the threshold is `thr_acq` again. A level between the two thresholds does not acquire.
- R6: Cycles with `lvl_vld` = 0 neither advance nor clear the count, and they do not change `cd_n`.
- R7: While `pwr_dn` is sampled high, the next edge sets `cd_oe` = 0 and `cd_n` = 1 and clears the count. Strobes during power-down are ignored. `cd_oe` returns to 1 on the first edge with `pwr_dn` low.
- R8: If `pwr_dn` is high in the same cycle as a strobe that would complete the window, power-down wins: `cd_n` stays 1 and the count is cleared.
- R9: A `hold_cnt` of 0 behaves like 1, so a single qualifying strobe toggles the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_dn | input | 1 | Power-down request |
| lvl_vld | input | 1 | Level sample strobe |
| lvl | input | LW | Unsigned received level |
| thr_acq | input | LW | Acquire threshold |
| hold_cnt | input | CW | Persistence window in strobes |
| cd_n | output | 1 | Carrier detect, 0 = carrier present |
| cd_oe | output | 1 | Output enable for `cd_n`, 0 = high impedance |

## Verification
Two events can land on the same edge: a strobe that completes the persistence window and a power-down request. The bench provokes this by sending two qualifying strobes, then raising `pwr_dn` together with the third. It judges the result by `cd_n` staying 1 and `cd_oe` dropping to 0. It then shows that one further strobe does not acquire, which proves the count was cleared. The other coincidence is the state flip and the threshold switch, which share one edge. Levels placed exactly on, and just beside, both thresholds show which threshold is in force after each flip.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
  typedef enum logic {CDQ_IDLE = 1'b0, CDQ_LOCK = 1'b1} cdq_state_e;
  // lowered threshold = (T * CDQ_NUM) >> CDQ_SHIFT, about -3 dB in amplitude
  localparam int unsigned CDQ_NUM   = 181;
  localparam int unsigned CDQ_SHIFT = 8;
endpackage

// File: rtl/cdq_thresh.sv
module cdq_thresh
  import cdq_pkg::*;
#(
  parameter int unsigned LW = 8
) (
  input  logic [LW-1:0] thr_acq,
  input  logic          locked,
  output logic [LW-1:0] thr_eff
);
  localparam int unsigned PW = LW + CDQ_SHIFT;

  logic [PW-1:0] prod;

  always_comb begin
    prod    = PW'(thr_acq) * PW'(CDQ_NUM);
    thr_eff = locked ? prod[CDQ_SHIFT +: LW] : thr_acq;
  end
endmodule

// File: rtl/cdq_compare.sv
module cdq_compare #(
  parameter int unsigned LW = 8
) (
  input  logic [LW-1:0] lvl,
  input  logic [LW-1:0] thr_eff,
  input  logic          locked,
  output logic          qual
);
  // idle: look for level strictly above; locked: strictly below
  always_comb qual = locked ? (lvl < thr_eff) : (lvl > thr_eff);
endmodule

// File: rtl/cdq_persist.sv
module cdq_persist #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          stb,
  input  logic          qual,
  input  logic [CW-1:0] dly,
  output logic          done
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   nxt;

  always_comb begin
    nxt  = {1'b0, cnt_q} + 1'b1;
    done = stb && qual && (nxt >= {1'b0, dly});
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (stb) begin
      if (qual && !done) cnt_q <= nxt[CW-1:0];
      else               cnt_q <= '0;
    end
  end
endmodule

// File: rtl/cdq_top.sv
module cdq_top
  import cdq_pkg::*;
#(
  parameter int unsigned LW = 8,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_dn,
  input  logic          lvl_vld,
  input  logic [LW-1:0] lvl,
  input  logic [LW-1:0] thr_acq,
  input  logic [CW-1:0] hold_cnt,
  output logic          cd_n,
  output logic          cd_oe
);
  cdq_state_e    state_q;
  logic          locked;
  logic [LW-1:0] thr_eff;
  logic          qual;
  logic          done;

  assign locked = (state_q == CDQ_LOCK);

  cdq_thresh #(.LW(LW)) u_thr (
    .thr_acq(thr_acq), .locked(locked), .thr_eff(thr_eff)
  );

  cdq_compare #(.LW(LW)) u_cmp (
    .lvl(lvl), .thr_eff(thr_eff), .locked(locked), .qual(qual)
  );

  cdq_persist #(.CW(CW)) u_per (
    .clk(clk), .rst(rst), .clr(pwr_dn), .stb(lvl_vld),
    .qual(qual), .dly(hold_cnt), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst || pwr_dn) begin
      state_q <= CDQ_IDLE;
      cd_n    <= 1'b1;
      cd_oe   <= 1'b0;
    end else begin
      cd_oe <= 1'b1;
      if (done) begin
        state_q <= locked ? CDQ_IDLE : CDQ_LOCK;
        cd_n    <= locked;
      end
    end
  end
endmodule

// File: rtl/cdq_chk.sv
module cdq_chk #(
  parameter int unsigned LW = 8,
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          pwr_dn,
  input logic          lvl_vld,
  input logic [LW-1:0] lvl,
  input logic [LW-1:0] thr_acq,
  input logic [CW-1:0] hold_cnt,
  input logic          cd_n,
  input logic          cd_oe
);
  function automatic logic [LW-1:0] low_of(input logic [LW-1:0] t);
    logic [LW+8:0] p;
    p = (LW+9)'(t) * (LW+9)'(181);
    return p[8 +: LW];
  endfunction

  // R7
  pd_force_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> (!cd_oe && cd_n));

  // R6
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!lvl_vld && !pwr_dn) |=> $stable(cd_n));

  // R2
  acquire_level_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cd_n) |-> ($past(lvl_vld) && !$past(pwr_dn) && ($past(lvl) > $past(thr_acq))));

  // R4
  loss_level_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(cd_n) && !$past(pwr_dn)) |-> ($past(lvl_vld) && ($past(lvl) < low_of($past(thr_acq)))));

  // R7
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cd_oe) |-> !$past(pwr_dn));
endmodule

bind cdq_top cdq_chk #(.LW(LW), .CW(CW)) u_cdq_chk (
  .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .lvl_vld(lvl_vld), .lvl(lvl),
  .thr_acq(thr_acq), .hold_cnt(hold_cnt), .cd_n(cd_n), .cd_oe(cd_oe)
);

// File: tb/tb_cdq_top.sv
`timescale 1ns/1ps
module tb_cdq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_dn = 1'b0;
  logic       lvl_vld = 1'b0;
  logic [7:0] lvl = '0;
  logic [7:0] thr_acq = 8'd100;
  logic [7:0] hold_cnt = 8'd3;
  logic       cd_n, cd_oe;
  int         errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  cdq_top #(.LW(8), .CW(8)) dut (
    .clk(clk), .rst(rst), .pwr_dn(pwr_dn), .lvl_vld(lvl_vld), .lvl(lvl),
    .thr_acq(thr_acq), .hold_cnt(hold_cnt), .cd_n(cd_n), .cd_oe(cd_oe)
  );

  // {level, expected cd_n after the strobe}; T=100 (low 70), window 3
  localparam logic [8:0] VEC [20] = '{
    {8'd150,1'b1}, {8'd150,1'b1}, {8'd50,1'b1},  {8'd150,1'b1},
    {8'd150,1'b1}, {8'd100,1'b1}, {8'd101,1'b1}, {8'd101,1'b1},
    {8'd101,1'b0}, {8'd80,1'b0},  {8'd69,1'b0},  {8'd69,1'b0},
    {8'd75,1'b0},  {8'd70,1'b0},  {8'd60,1'b0},  {8'd60,1'b0},
    {8'd60,1'b1},  {8'd90,1'b1},  {8'd90,1'b1},  {8'd90,1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic [7:0] l);
    @(negedge clk);
    lvl = l; lvl_vld = 1'b1;
    @(negedge clk);
    lvl_vld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cd_n in reset", cd_n, 1'b1);
    chk("R1 cd_oe in reset", cd_oe, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cd_oe after reset", cd_oe, 1'b1);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 20; i++) begin
      pulse(VEC[i][8:1]);
      chk($sformatf("R2/R3/R4/R5 vector %0d", i), cd_n, VEC[i][0]);
    end

    // R6: gaps neither count nor clear
    @(negedge clk); lvl = 8'd200;
    repeat (5) @(negedge clk);
    chk("R6 no strobe no acquire", cd_n, 1'b1);
    pulse(8'd200); pulse(8'd200);
    repeat (4) @(negedge clk);
    chk("R6 two strobes", cd_n, 1'b1);
    pulse(8'd200);
    chk("R6 gap kept count", cd_n, 1'b0);

    // R7: power-down forces and clears
    @(negedge clk); pwr_dn = 1'b1;
    @(negedge clk);
    chk("R7 cd_n forced", cd_n, 1'b1);
    chk("R7 cd_oe off", cd_oe, 1'b0);
    pulse(8'd200); pulse(8'd200); pulse(8'd200);
    chk("R7 strobes ignored", cd_n, 1'b1);
    pwr_dn = 1'b0;
    @(negedge clk);
    chk("R7 cd_oe back", cd_oe, 1'b1);
    pulse(8'd200); pulse(8'd200);
    chk("R7 count cleared", cd_n, 1'b1);
    pulse(8'd200);
    chk("R7 reacquire", cd_n, 1'b0);
    pulse(8'd10); pulse(8'd10); pulse(8'd10);
    chk("R4 lost", cd_n, 1'b1);

    // R8: power-down on the completing strobe
    pulse(8'd200); pulse(8'd200);
    @(negedge clk);
    lvl = 8'd200; lvl_vld = 1'b1; pwr_dn = 1'b1;
    @(negedge clk);
    lvl_vld = 1'b0; pwr_dn = 1'b0;
    chk("R8 pd wins cd_n", cd_n, 1'b1);
    chk("R8 pd wins cd_oe", cd_oe, 1'b0);
    pulse(8'd200);
    chk("R8 count cleared", cd_n, 1'b1);
    pulse(8'd200); pulse(8'd200);
    chk("R8 acquire after", cd_n, 1'b0);
    pulse(8'd10); pulse(8'd10); pulse(8'd10);
    chk("R8 lost", cd_n, 1'b1);

    // R9: zero window acts as one
    hold_cnt = 8'd0;
    pulse(8'd200);
    chk("R9 acquire one strobe", cd_n, 1'b0);
    pulse(8'd10);
    chk("R9 lose one strobe", cd_n, 1'b1);
    hold_cnt = 8'd3;

    // R1: reset clears a partial count
    pulse(8'd200); pulse(8'd200);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    pulse(8'd200);
    chk("R1 reset cleared count", cd_n, 1'b1);
    pulse(8'd200); pulse(8'd200);
    chk("R1 full window after reset", cd_n, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule